// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a 32-bit down-counting watchdog with a small word-addressed register interface. Software places a start value in the reload register and arms or refreshes the counter by writing one fixed key word to the kick register. While counting is enabled, the counter drops by one on every tick. The tick is either every clock or a 1 MHz enable strobe supplied from outside. If software stops kicking, the count runs out and the block reports it. It can issue a one-cycle reset request and a one-cycle external signal pulse. It also records a sticky timeout flag, and a secondary-boot flag when that option is chosen. A reset-scope code is driven alongside the request for the chip's reset distribution.

A pretimeout threshold, held in the upper bits of the control register, can raise a sticky interrupt while the count is still above zero. This gives software a last chance to act. A write to the clear register drops all three status flags together.

A three-state machine governs the counter. ST_HALT is the state while counting is disabled. ST_COUNT is entered when the enable bit is set. ST_EXPIRED is entered from ST_HALT or ST_COUNT on the tick that takes the count to zero. A valid key write leaves any state and goes to ST_COUNT or ST_HALT, according to the enable bit. Outside a key write, ST_EXPIRED holds. ST_HALT and ST_COUNT follow the enable bit.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the count reads 0xFFFFFFFF, the reload and control registers read 0, the status register reads 0, and rst_req, ext_req and irq are low.
- R2: Registers sit at byte offsets 0x00 (current count, read only), 0x04 (reload), 0x08 (kick, reads 0), 0x0C (control), 0x10 (status) and 0x14 (clear, reads 0). Reload and control read back what was written.
- R3: A write of exactly 0x00004755 to 0x08 copies the reload value into the count at that clock edge. Any other word written there leaves the count unchanged.
- R4: While control bit 0 is 1, the count falls by one per tick. The tick is every clock when control bit 4 is 0, and each clock with tick_1m high when bit 4 is 1.
- R5: While control bit 0 is 0, the count holds its value.
- R6: A tick that finds the count at 1 or 0 while enabled sets the count to 0. The count then stays at 0 until a key write, and status bit 0 (timed out) is set.
- R7: On that expiring edge rst_req goes high for exactly one cycle if control bit 1 is 1. ext_req behaves the same way if control bit 3 is 1. Neither pulses when its bit is 0.
- R8: rst_scope always equals control bits 6:5 (00 SoC, 01 full chip, 10 CPU only).
- R9: Expiry sets status bit 1 (secondary boot) only when control bit 7 is 1.
- R10: With control bits 0 and 2 set, the count not expired, and the count at or below the threshold, status bit 2 and irq become set. The threshold is control bits 31:THR_LSB with the bits below zeroed, and THR_LSB is 10 or 12. The flag appears one edge after the count first meets the threshold and stays set after counting stops.
- R11: A write to 0x14 with bit 0 set clears status bits 2:0 and irq. A write there with bit 0 clear changes nothing.
- R12: When a flag is set and cleared on the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1m | input | 1 | 1 MHz count strobe, used when control bit 4 is set |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| rst_req | output | 1 | One-cycle reset request on expiry |
| rst_scope | output | 2 | Reset scope code from control bits 6:5 |
| ext_req | output | 1 | One-cycle external signal pulse on expiry |
| irq | output | 1 | Sticky pretimeout interrupt |

## Verification
Two functions can fall on the same clock edge: the expiry of the counter and a software write to the clear register. Both touch the status flags. The bench arms a count of three at the full clock rate and idles two cycles. It then times the clear write so that it commits on the very edge where the count reaches zero. It judges the outcome in two ways: rst_req must be high in the cycle that follows, and the status register must still show the timeout flag, as R12 requires.

// File: rtl/kwd_pkg.sv
`timescale 1ns/1ps
package kwd_pkg;

    localparam logic [15:0] KICK_KEY = 16'h4755;

    // word indices (byte offset / 4)
    localparam int W_COUNT  = 0;
    localparam int W_RELOAD = 1;
    localparam int W_KICK   = 2;
    localparam int W_CTRL   = 3;
    localparam int W_STAT   = 4;
    localparam int W_CLEAR  = 5;

    // control bit positions
    localparam int C_RUN     = 0;
    localparam int C_SYSRST  = 1;
    localparam int C_PREIRQ  = 2;
    localparam int C_EXTSIG  = 3;
    localparam int C_SLOWTCK = 4;
    localparam int C_SCOPE   = 5;
    localparam int C_ALTBOOT = 7;

    // status bit positions
    localparam int S_TIMEOUT = 0;
    localparam int S_ALTBOOT = 1;
    localparam int S_PRE     = 2;
    localparam int STAT_W    = 3;

    typedef enum logic [1:0] {
        SCOPE_SOC  = 2'b00,
        SCOPE_CHIP = 2'b01,
        SCOPE_CPU  = 2'b10,
        SCOPE_RSVD = 2'b11
    } scope_e;

    typedef enum logic [1:0] {
        ST_HALT    = 2'b00,
        ST_COUNT   = 2'b01,
        ST_EXPIRED = 2'b10
    } wd_state_e;

endpackage

// File: rtl/kwd_regfile.sv
`timescale 1ns/1ps
module kwd_regfile
    import kwd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [DATA_W-1:0]     cnt,
    input  logic [STAT_W-1:0]     stat,
    output logic [DATA_W-1:0]     rdata,
    output logic [DATA_W-1:0]     ctrl_q,
    output logic [DATA_W-1:0]     reload_q,
    output logic                  kick_hit,
    output logic                  clr_hit
);
    localparam int WORD_AW = ADDR_W - 2;

    logic [WORD_AW-1:0] widx;
    logic               sel_ctrl;
    logic               sel_reload;
    logic [1:0]         unused_byte_lane;

    assign widx             = addr[ADDR_W-1:2];
    assign unused_byte_lane = addr[1:0];

    assign sel_ctrl   = wr && (widx == WORD_AW'(W_CTRL));
    assign sel_reload = wr && (widx == WORD_AW'(W_RELOAD));
    assign kick_hit   = wr && (widx == WORD_AW'(W_KICK))
                           && (wdata == DATA_W'(KICK_KEY));
    assign clr_hit    = wr && (widx == WORD_AW'(W_CLEAR)) && wdata[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            reload_q <= '0;
        end else begin
            if (sel_ctrl)   ctrl_q   <= wdata;
            if (sel_reload) reload_q <= wdata;
        end
    end

    always_comb begin
        case (widx)
            WORD_AW'(W_COUNT):  rdata = cnt;
            WORD_AW'(W_RELOAD): rdata = reload_q;
            WORD_AW'(W_CTRL):   rdata = ctrl_q;
            WORD_AW'(W_STAT):   rdata = {{(DATA_W-STAT_W){1'b0}}, stat};
            default:            rdata = '0;
        endcase
    end

endmodule

// File: rtl/kwd_counter.sv
`timescale 1ns/1ps
module kwd_counter
    import kwd_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             kick,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output logic             expire,
    output logic             running
);
    wd_state_e  state_q, state_d;
    logic       dec;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT, ST_COUNT: begin
                if (kick)        state_d = en ? ST_COUNT : ST_HALT;
                else if (expire) state_d = ST_EXPIRED;
                else             state_d = en ? ST_COUNT : ST_HALT;
            end
            ST_EXPIRED: begin
                if (kick)        state_d = en ? ST_COUNT : ST_HALT;
            end
            default:             state_d = ST_HALT;
        endcase
    end

    // outputs of the machine
    always_comb begin
        running = en && (state_q != ST_EXPIRED);
        dec     = running && tick && !kick;
        expire  = dec && (cnt <= CNT_W'(1));
    end

    // count register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '1;
        end else if (kick) begin
            cnt <= reload;
        end else if (dec) begin
            cnt <= expire ? '0 : cnt - CNT_W'(1);
        end
    end

endmodule

// File: rtl/kwd_status.sv
`timescale 1ns/1ps
module kwd_status
    import kwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              expire,
    input  logic              altboot_sel,
    input  logic              pre_hit,
    input  logic              clr,
    output logic [STAT_W-1:0] stat,
    output logic              irq
);
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] stat_d;

    always_comb begin
        set_vec            = '0;
        set_vec[S_TIMEOUT] = expire;
        set_vec[S_ALTBOOT] = expire && altboot_sel;
        set_vec[S_PRE]     = pre_hit;
    end

    // a set on the same edge as a clear survives
    for (genvar b = 0; b < STAT_W; b++) begin : g_flag
        assign stat_d[b] = set_vec[b] | (stat[b] & ~clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= stat_d;
    end

    assign irq = stat[S_PRE];

endmodule

// File: rtl/keyed_watchdog.sv
`timescale 1ns/1ps
module keyed_watchdog
    import kwd_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 5,
    parameter int THR_LSB = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1m,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rst_req,
    output logic [1:0]        rst_scope,
    output logic              ext_req,
    output logic              irq
);
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] reload_q;
    logic [DATA_W-1:0] cnt;
    logic [STAT_W-1:0] stat;
    logic              kick_hit;
    logic              clr_hit;
    logic              tick_sel;
    logic              expire;
    logic              running;
    logic              pre_hit;
    logic [DATA_W-1:0] thr;
    logic              unused_ctrl_bits;

    kwd_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .cnt      (cnt),
        .stat     (stat),
        .rdata    (bus_rdata),
        .ctrl_q   (ctrl_q),
        .reload_q (reload_q),
        .kick_hit (kick_hit),
        .clr_hit  (clr_hit)
    );

    assign tick_sel = ctrl_q[C_SLOWTCK] ? tick_1m : 1'b1;

    kwd_counter #(.CNT_W(DATA_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (ctrl_q[C_RUN]),
        .tick    (tick_sel),
        .kick    (kick_hit),
        .reload  (reload_q),
        .cnt     (cnt),
        .expire  (expire),
        .running (running)
    );

    assign thr     = {ctrl_q[DATA_W-1:THR_LSB], {THR_LSB{1'b0}}};
    assign pre_hit = ctrl_q[C_PREIRQ] && running && (cnt <= thr);
    assign unused_ctrl_bits = ^ctrl_q[THR_LSB-1:C_ALTBOOT+1];

    kwd_status u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .expire      (expire),
        .altboot_sel (ctrl_q[C_ALTBOOT]),
        .pre_hit     (pre_hit),
        .clr         (clr_hit),
        .stat        (stat),
        .irq         (irq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req <= 1'b0;
            ext_req <= 1'b0;
        end else begin
            rst_req <= expire && ctrl_q[C_SYSRST];
            ext_req <= expire && ctrl_q[C_EXTSIG];
        end
    end

    assign rst_scope = ctrl_q[C_SCOPE+1:C_SCOPE];

endmodule

// File: rtl/kwd_checker.sv
`timescale 1ns/1ps
module kwd_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              tick,
    input logic              kick,
    input logic              clr,
    input logic [DATA_W-1:0] cnt,
    input logic [DATA_W-1:0] reload,
    input logic              rst_req,
    input logic              irq,
    input logic              timeout_flag
);
    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);                                         // R7
    AST_RST_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (cnt == '0));                                      // R6
    AST_KICK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (cnt == $past(reload)));                              // R3
    AST_DEC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && !kick && cnt > DATA_W'(1)) |=> (cnt == $past(cnt) - DATA_W'(1))); // R4
    AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !kick) |=> $stable(cnt));                              // R5
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr) |=> irq);                                        // R10
    AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_flag && !clr) |=> timeout_flag);                      // R6
endmodule

bind keyed_watchdog kwd_checker #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (ctrl_q[0]),
    .tick         (tick_sel),
    .kick         (kick_hit),
    .clr          (clr_hit),
    .cnt          (cnt),
    .reload       (reload_q),
    .rst_req      (rst_req),
    .irq          (irq),
    .timeout_flag (stat[0])
);

// File: tb/keyed_watchdog_bench.sv
`timescale 1ns/1ps
module keyed_watchdog_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1m = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req;
    logic [1:0]  rst_scope;
    logic        ext_req;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    keyed_watchdog u_keyed_watchdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_1m   (tick_1m),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rst_req   (rst_req),
        .rst_scope (rst_scope),
        .ext_req   (ext_req),
        .irq       (irq)
    );

    localparam logic [4:0] A_CNT = 5'h00, A_RLD = 5'h04, A_KICK = 5'h08,
                           A_CTL = 5'h0C, A_STA = 5'h10, A_CLR = 5'h14;
    localparam logic [31:0] KEY = 32'h0000_4755;

    // {reload, enabled idle cycles, expected frozen count}
    localparam int NV = 7;
    localparam logic [79:0] VECS [NV] = '{
        {32'd100,          16'd10, 32'd89},
        {32'd5,            16'd3,  32'd1},
        {32'd5,            16'd4,  32'd0},
        {32'd3,            16'd20, 32'd0},
        {32'd0,            16'd0,  32'd0},
        {32'h1234_5678,    16'd7,  32'h1234_5670},
        {32'd2,            16'd0,  32'd1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // called at a negedge; commits at the next posedge, returns at the negedge after
    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int first_rst, n_rst, n_ext;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        bus_read(A_CNT, rd); check("R1 count", rd, 32'hFFFF_FFFF);
        bus_read(A_RLD, rd); check("R1 reload", rd, 32'h0);
        bus_read(A_CTL, rd); check("R1 control", rd, 32'h0);
        bus_read(A_STA, rd); check("R1 status", rd, 32'h0);
        check("R1 outputs", {29'd0, rst_req, ext_req, irq}, 32'h0);

        // R2 map and readback
        bus_write(A_RLD, 32'hDEAD_BEEF);
        bus_read(A_RLD, rd);  check("R2 reload readback", rd, 32'hDEAD_BEEF);
        bus_write(A_CTL, 32'h0000_0060);
        bus_read(A_CTL, rd);  check("R2 control readback", rd, 32'h0000_0060);
        bus_read(A_KICK, rd); check("R2 kick reads zero", rd, 32'h0);
        bus_read(A_CLR, rd);  check("R2 clear reads zero", rd, 32'h0);
        bus_read(A_CNT, rd);  check("R2 count unchanged", rd, 32'hFFFF_FFFF);
        check("R8 scope reserved code", {30'd0, rst_scope}, 32'd3);

        // table: load, run N cycles, freeze, read
        for (int v = 0; v < NV; v++) begin
            logic [31:0] r_ld;
            logic [15:0] n_run;
            logic [31:0] e_cnt;
            {r_ld, n_run, e_cnt} = VECS[v];
            bus_write(A_CTL, 32'h0);
            bus_write(A_RLD, r_ld);
            bus_write(A_KICK, KEY);
            bus_read(A_CNT, rd); check("R3 key loads reload", rd, r_ld);
            bus_write(A_CTL, 32'h1);
            idle(int'(n_run));
            bus_write(A_CTL, 32'h0);
            bus_read(A_CNT, rd); check("R4 decrement per clock", rd, e_cnt);
            idle(3);
            bus_read(A_CNT, rd); check("R5 frozen when disabled", rd, e_cnt);
        end

        // R3 wrong keys ignored
        bus_write(A_RLD, 32'd1000);
        bus_write(A_KICK, KEY);
        bus_write(A_RLD, 32'd7);
        bus_write(A_KICK, 32'h0000_4756);
        bus_read(A_CNT, rd); check("R3 near key ignored", rd, 32'd1000);
        bus_write(A_KICK, 32'h0001_4755);
        bus_read(A_CNT, rd); check("R3 upper bits key ignored", rd, 32'd1000);

        // R4 slow tick source
        bus_write(A_CLR, 32'h1);
        bus_write(A_RLD, 32'd10);
        bus_write(A_KICK, KEY);
        bus_write(A_CTL, 32'h11);
        idle(5);
        bus_read(A_CNT, rd); check("R4 no strobe no count", rd, 32'd10);
        for (int k = 0; k < 3; k++) begin
            tick_1m = 1'b1;
            @(negedge clk);
            tick_1m = 1'b0;
            @(negedge clk);
        end
        bus_read(A_CNT, rd); check("R4 one step per strobe", rd, 32'd7);
        bus_write(A_CTL, 32'h0);

        // R6 R7 R8 R9 expiry with reset, external signal, full chip, alt boot
        bus_write(A_CLR, 32'h1);
        bus_write(A_RLD, 32'd4);
        bus_write(A_KICK, KEY);
        bus_write(A_CTL, 32'h0000_00AB);
        first_rst = 0; n_rst = 0; n_ext = 0;
        for (int i = 1; i <= 8; i++) begin
            @(negedge clk);
            if (rst_req) begin
                n_rst++;
                if (first_rst == 0) first_rst = i;
            end
            if (ext_req) n_ext++;
        end
        check("R7 reset pulse cycle", first_rst, 4);
        check("R7 reset pulse width", n_rst, 1);
        check("R7 external pulse width", n_ext, 1);
        check("R8 scope full chip", {30'd0, rst_scope}, 32'd1);
        bus_read(A_STA, rd); check("R9 timeout and alt boot", rd, 32'h3);
        idle(3);
        bus_read(A_CNT, rd); check("R6 count stays zero", rd, 32'h0);

        // R7 R9 R11 expiry without reset or external enable
        bus_write(A_CLR, 32'h1);
        bus_read(A_STA, rd); check("R11 clear drops flags", rd, 32'h0);
        bus_write(A_CTL, 32'h0);
        bus_write(A_RLD, 32'd2);
        bus_write(A_KICK, KEY);
        bus_write(A_CTL, 32'h1);
        n_rst = 0; n_ext = 0;
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            if (rst_req) n_rst++;
            if (ext_req) n_ext++;
        end
        check("R7 no reset when disabled", n_rst, 0);
        check("R7 no external when disabled", n_ext, 0);
        check("R8 scope soc", {30'd0, rst_scope}, 32'd0);
        bus_read(A_STA, rd); check("R9 timeout without alt boot", rd, 32'h1);
        bus_write(A_CLR, 32'h0);
        bus_read(A_STA, rd); check("R11 bit0 clear has no effect", rd, 32'h1);
        bus_write(A_CLR, 32'h1);
        bus_read(A_STA, rd); check("R11 clear", rd, 32'h0);

        bus_write(A_CTL, 32'h40);
        check("R8 scope cpu", {30'd0, rst_scope}, 32'd2);

        // R10 pretimeout at threshold 0x800 (bits 31:10)
        bus_write(A_CTL, 32'h0);
        bus_write(A_RLD, 32'd3000);
        bus_write(A_KICK, KEY);
        bus_write(A_CTL, 32'h0000_0805);
        idle(952);
        check("R10 irq low above threshold", {31'd0, irq}, 32'd0);
        idle(1);
        check("R10 irq at threshold", {31'd0, irq}, 32'd1);
        bus_read(A_STA, rd); check("R10 status bit2", rd, 32'h4);
        bus_write(A_CTL, 32'h0);
        idle(5);
        check("R10 irq sticky", {31'd0, irq}, 32'd1);
        bus_write(A_CLR, 32'h1);
        check("R11 irq cleared", {31'd0, irq}, 32'd0);

        // R12 clear commits on the expiring edge
        bus_write(A_RLD, 32'd3);
        bus_write(A_KICK, KEY);
        bus_write(A_CTL, 32'h3);
        idle(2);
        bus_write(A_CLR, 32'h1);
        check("R7 reset pulse beside clear", {31'd0, rst_req}, 32'd1);
        bus_read(A_STA, rd); check("R12 set wins over clear", rd, 32'h1);
        bus_write(A_CLR, 32'h1);
        bus_read(A_STA, rd); check("R11 later clear", rd, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule